// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Write Engine

This block is the receive side of a two-wire serial EEPROM slave. It watches clock and data lines that are already synchronised to the system clock, finds Start and Stop framing, and checks the first byte of each transfer against a fixed device code and a three-bit strap. It pulls the data line low on the ninth clock of every byte it accepts. After a write-type control byte it collects a two-byte word address and then any number of data bytes.

Each accepted data byte goes out on a one-clock write strobe with its full address, ready for a page cache. The low page bits of the address pointer advance after every byte and wrap inside the page. A Stop that closes a write with at least one data byte raises a one-clock commit request. A read-type control byte is acknowledged and reported by a one-clock flag, and nothing else is done for it. While the external busy input is high, no byte is acknowledged.

Top module: `serial_eeprom_write_slave`

## Requirements
- R1: After reset, sda_drive, wr_valid, commit_req and read_req are 0 and addr_ptr is 0.
- R2: The block acknowledges a control byte (sda_drive high for the ninth clock) only if bits 7..4 equal 1010 and bits 3..1 equal strap_sel. A mismatching control byte is not acknowledged, and every byte up to the next Start is then ignored without acknowledge or capture.
- R3: Bit 0 of the control byte selects the direction, with 1 for read. A matching read control byte is acknowledged, read_req pulses for one clock, and nothing is captured.
- R4: After a matching write control byte (bit 0 = 0), two address bytes follow, high byte first, each sent MSB first and each acknowledged. The pointer is loaded as {control bits 3..1, high byte bits 4..0, low byte}, so the top three bits of the high byte are ignored.
- R5: Each later data byte is acknowledged and shown as a one-clock wr_valid pulse, with wr_data holding the byte and wr_addr holding the pointer before it advances.
- R6: After each data byte, the low PAGE_BITS bits of the pointer increment and wrap to 0 within the page. The upper bits do not change.
- R7: A Stop after at least one data byte gives a one-clock commit_req. A Stop after only the address bytes leaves addr_ptr loaded and gives no commit_req.
- R8: If busy_i is high when a byte completes, that byte is not acknowledged and not captured, and the engine idles until the next Start, so no commit follows.
- R9: A Start at any bit position restarts bit counting and waits for a control byte.
- R10: sda_drive is asserted only while SCL is low after the eighth bit, and it is released at the falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data |
| strap_sel | input | 3 | Device select strap |
| busy_i | input | 1 | Internal write in progress; blocks acknowledges |
| sda_drive | output | 1 | 1 = pull data line low |
| wr_valid | output | 1 | One-clock strobe per accepted data byte |
| wr_addr | output | ADDR_W (16) | Address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| addr_ptr | output | ADDR_W (16) | Current address pointer |
| commit_req | output | 1 | One-clock request to program the cache |
| read_req | output | 1 | One-clock flag for a read control byte |

## Verification
The bench builds the block with its defaults: WORD_BITS = 13, which gives a 16-bit address, and PAGE_BITS = 6, with the strap tied to 101. With a 64-byte page, a short burst that starts at low byte 0x7E crosses the page wrap in two bytes, and the 0x40 bit shows that the bits above the page stay fixed. A high address byte of 0xFF shows that its top three bits are dropped. Busy is raised both before a control byte and in the middle of a data phase, and a Start is inserted partway through a byte.

// File: rtl/eeprom_wfe_pkg.sv
// Shared constants and the engine state type for the EEPROM write slave.
// Assumes a control byte of four code bits, three select bits and a direction bit.
package eeprom_wfe_pkg;
    localparam int SEL_W = 3;
    localparam logic [3:0] CTRL_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_DATA
    } wfe_state_t;
endpackage

// File: rtl/i2c_line_events.sv
// Derives bus clock edges and Start/Stop conditions from synchronised lines.
// Assumes scl_i and sda_i are glitch-free and already in the clk domain.
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Keep the previous line levels; an idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
    assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_receiver.sv
// Shifts in eight bits MSB first on clock rises and marks the ninth-clock window.
// Assumes restart is asserted on every Start or Stop to realign the counter.
module i2c_byte_receiver (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       restart,
    input  logic       sda_i,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       ack_open,
    output logic       ack_close
);
    logic [3:0] bit_cnt;
    logic [6:0] shreg;

    // Count bit clocks, assemble the byte and flag the acknowledge window edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= 4'd0;
            shreg     <= 7'd0;
            byte_done <= 1'b0;
            byte_val  <= 8'd0;
            ack_open  <= 1'b0;
            ack_close <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            ack_open  <= 1'b0;
            ack_close <= 1'b0;
            if (restart) begin
                bit_cnt <= 4'd0;
            end else if (scl_rise) begin
                if (bit_cnt < 4'd8) begin
                    shreg   <= {shreg[5:0], sda_i};
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'd7) begin
                        byte_done <= 1'b1;
                        byte_val  <= {shreg, sda_i};
                    end
                end else if (bit_cnt == 4'd8) begin
                    bit_cnt <= 4'd9;
                end
            end else if (scl_fall) begin
                if (bit_cnt == 4'd8) begin
                    ack_open <= 1'b1;
                end else if (bit_cnt == 4'd9) begin
                    ack_close <= 1'b1;
                    bit_cnt   <= 4'd0;
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_addr_pointer.sv
// Address pointer with a full load and a page-local increment that wraps.
// Assumes PAGE_BITS is between 1 and ADDR_W.
module eeprom_addr_pointer #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] stepped;

    generate
        if (PAGE_BITS >= ADDR_W) begin : g_whole
            assign stepped = ptr + 1'b1;
        end else begin : g_page
            logic [PAGE_BITS-1:0] low_next;
            assign low_next = ptr[PAGE_BITS-1:0] + 1'b1;
            assign stepped  = {ptr[ADDR_W-1:PAGE_BITS], low_next};
        end
    endgenerate

    // Load a new pointer or advance within the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= stepped;
        end
    end
endmodule

// File: rtl/serial_eeprom_write_slave.sv
// Write front-end of a two-wire EEPROM slave: control match, address capture,
// per-byte write strobes and a commit on Stop. Assumes synchronised inputs
// and that the bus clock half-period spans at least three system clocks.
module serial_eeprom_write_slave
    import eeprom_wfe_pkg::*;
#(
    parameter int WORD_BITS = 13,
    parameter int PAGE_BITS = 6,
    localparam int ADDR_W   = SEL_W + WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  strap_sel,
    input  logic              busy_i,
    output logic              sda_drive,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] addr_ptr,
    output logic              commit_req,
    output logic              read_req
);
    localparam int HI_W = WORD_BITS - 8;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic byte_done, ack_open, ack_close;
    logic [7:0] byte_val;

    wfe_state_t        state;
    logic              ack_arm;
    logic              got_data;
    logic [SEL_W-1:0]  sel_q;
    logic [HI_W-1:0]   hi_q;
    logic              accept;
    logic              ctrl_hit;
    logic              ptr_load;
    logic              ptr_step;
    logic [ADDR_W-1:0] load_val;

    i2c_line_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_byte_receiver u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .restart   (start_ev | stop_ev),
        .sda_i     (sda_i),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .ack_open  (ack_open),
        .ack_close (ack_close)
    );

    // Decode which completed byte is accepted and what it does to the pointer.
    always_comb begin
        accept   = byte_done && !busy_i;
        ctrl_hit = (byte_val[7:4] == CTRL_CODE) && (byte_val[3:1] == strap_sel);
        ptr_load = accept && (state == ST_ALO);
        ptr_step = accept && (state == ST_DATA);
        load_val = {sel_q, hi_q, byte_val};
    end

    eeprom_addr_pointer #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (load_val),
        .step     (ptr_step),
        .ptr      (addr_ptr)
    );

    // Transfer sequencing, acknowledge drive and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ack_arm    <= 1'b0;
            got_data   <= 1'b0;
            sel_q      <= '0;
            hi_q       <= '0;
            sda_drive  <= 1'b0;
            wr_valid   <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            commit_req <= 1'b0;
            read_req   <= 1'b0;
        end else begin
            wr_valid   <= 1'b0;
            commit_req <= 1'b0;
            read_req   <= 1'b0;
            if (start_ev) begin
                state     <= ST_CTRL;
                ack_arm   <= 1'b0;
                sda_drive <= 1'b0;
                got_data  <= 1'b0;
            end else if (stop_ev) begin
                commit_req <= (state == ST_DATA) && got_data;
                state      <= ST_IDLE;
                ack_arm    <= 1'b0;
                sda_drive  <= 1'b0;
                got_data   <= 1'b0;
            end else begin
                if (byte_done) begin
                    ack_arm <= 1'b0;
                    if (busy_i) begin
                        state <= ST_IDLE;
                    end else begin
                        case (state)
                            ST_CTRL: begin
                                if (ctrl_hit) begin
                                    ack_arm <= 1'b1;
                                    sel_q   <= byte_val[3:1];
                                    if (byte_val[0]) begin
                                        read_req <= 1'b1;
                                        state    <= ST_IDLE;
                                    end else begin
                                        state <= ST_AHI;
                                    end
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                hi_q    <= byte_val[HI_W-1:0];
                                ack_arm <= 1'b1;
                                state   <= ST_ALO;
                            end
                            ST_ALO: begin
                                ack_arm  <= 1'b1;
                                got_data <= 1'b0;
                                state    <= ST_DATA;
                            end
                            ST_DATA: begin
                                ack_arm  <= 1'b1;
                                got_data <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_addr  <= addr_ptr;
                                wr_data  <= byte_val;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                if (ack_open) begin
                    sda_drive <= ack_arm;
                    ack_arm   <= 1'b0;
                end else if (ack_close) begin
                    sda_drive <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_wfe_checker.sv
// Protocol checks on the write slave's outputs; attached by bind below.
// Assumes outputs are registered and observed on the rising clock edge.
module eeprom_wfe_checker #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_drive,
    input logic              wr_valid,
    input logic              commit_req,
    input logic              read_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] addr_ptr
);
    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, commit_req, read_req}));

    assert_commit_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> !commit_req);

    assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |=> !read_req);

    assert_ack_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive) |-> !scl_i);

    generate
        if (PAGE_BITS < ADDR_W) begin : g_step
            assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_valid |-> (addr_ptr[ADDR_W-1:PAGE_BITS] == wr_addr[ADDR_W-1:PAGE_BITS])
                          && (addr_ptr[PAGE_BITS-1:0] == PAGE_BITS'(wr_addr[PAGE_BITS-1:0] + 1'b1)));
        end
    endgenerate
endmodule

bind serial_eeprom_write_slave eeprom_wfe_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_drive  (sda_drive),
    .wr_valid   (wr_valid),
    .commit_req (commit_req),
    .read_req   (read_req),
    .wr_addr    (wr_addr),
    .addr_ptr   (addr_ptr)
);

// File: tb/sim_serial_eeprom_write_slave.sv
module sim_serial_eeprom_write_slave;
    localparam int H = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic busy = 1'b0;
    logic sda_drive, wr_valid, commit_req, read_req;
    logic [15:0] wr_addr, addr_ptr;
    logic [7:0] wr_data;
    logic sda_line;

    int tests = 0;
    int fails = 0;
    int settle = 0;
    int cycles = 0;
    bit exp_drive = 1'b0;
    bit running = 1'b0;
    bit finished = 1'b0;
    int exp_commit = 0;
    int exp_read = 0;
    logic [15:0] q_addr[$];
    logic [7:0]  q_data[$];
    logic [15:0] model_ptr = 16'h0;

    assign sda_line = m_sda & ~sda_drive;

    always #5 clk = ~clk;

    serial_eeprom_write_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .strap_sel  (STRAP),
        .busy_i     (busy),
        .sda_drive  (sda_drive),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .addr_ptr   (addr_ptr),
        .commit_req (commit_req),
        .read_req   (read_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step_ptr(input logic [15:0] p);
        logic [5:0] low;
        low = p[5:0] + 6'd1;
        return {p[15:6], low};
    endfunction

    // Per-clock comparison against the behavioural model.
    always @(posedge clk) begin
        #2;
        cycles++;
        if (running) begin
            settle++;
            if (settle >= 3)
                check(sda_drive == exp_drive, "R10 ack drive", sda_drive, exp_drive);
            if (wr_valid) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R5 unexpected write", wr_addr, 0);
                end else begin
                    logic [15:0] ea;
                    logic [7:0] ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    check(wr_addr == ea, "R6 write address", wr_addr, ea);
                    check(wr_data == ed, "R5 write data", wr_data, ed);
                end
            end
            if (commit_req) begin
                check(exp_commit > 0, "R7 commit", 1, exp_commit);
                if (exp_commit > 0) exp_commit--;
            end
            if (read_req) begin
                check(exp_read > 0, "R3 read flag", 1, exp_read);
                if (exp_read > 0) exp_read--;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_scl(input logic v);
        @(negedge clk);
        m_scl = v;
        settle = 0;
    endtask

    task automatic set_sda(input logic v);
        @(negedge clk);
        m_sda = v;
        settle = 0;
    endtask

    task automatic start_cond();
        set_sda(1'b1); wait_clks(H);
        set_scl(1'b1); wait_clks(H);
        set_sda(1'b0); exp_drive = 1'b0; wait_clks(H);
        set_scl(1'b0); wait_clks(H);
    endtask

    task automatic stop_cond();
        set_sda(1'b0); wait_clks(H);
        set_scl(1'b1); wait_clks(H);
        set_sda(1'b1); exp_drive = 1'b0; wait_clks(H);
    endtask

    task automatic put_bit(input logic b);
        set_sda(b); wait_clks(H);
        set_scl(1'b1); wait_clks(H);
        set_scl(1'b0); wait_clks(H);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            set_sda(v[i]); wait_clks(H);
            set_scl(1'b1); wait_clks(H);
            set_scl(1'b0);
            if (i == 0) exp_drive = ack;
            wait_clks(H);
        end
        set_sda(1'b1); wait_clks(H);
        set_scl(1'b1); wait_clks(H);
        check(sda_line == !ack, tag, sda_line, !ack);
        set_scl(1'b0); exp_drive = 1'b0; wait_clks(H);
    endtask

    task automatic drained(input string tag);
        wait_clks(4);
        check(q_addr.size() == 0, tag, q_addr.size(), 0);
        check(exp_commit == 0, tag, exp_commit, 0);
        check(exp_read == 0, tag, exp_read, 0);
    endtask

    task automatic write_burst(input logic [7:0] hi, input logic [7:0] lo,
                               input int n, input logic [7:0] seed, input string tag);
        model_ptr = {STRAP, hi[4:0], lo};
        start_cond();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b1, "R2 control ack");
        send_byte(hi, 1'b1, "R4 high address ack");
        send_byte(lo, 1'b1, "R4 low address ack");
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 37);
            q_addr.push_back(model_ptr);
            q_data.push_back(d);
            model_ptr = step_ptr(model_ptr);
            send_byte(d, 1'b1, "R5 data ack");
        end
        if (n > 0) exp_commit++;
        stop_cond();
        drained(tag);
        check(addr_ptr == model_ptr, {tag, " pointer"}, addr_ptr, model_ptr);
    endtask

    initial begin
        wait_clks(5);
        // R1: reset state
        check(sda_drive == 1'b0 && wr_valid == 1'b0, "R1 reset strobes", {sda_drive, wr_valid}, 0);
        check(commit_req == 1'b0 && read_req == 1'b0, "R1 reset flags", {commit_req, read_req}, 0);
        check(addr_ptr == 16'h0, "R1 reset pointer", addr_ptr, 0);
        rst_n = 1'b1;
        running = 1'b1;
        wait_clks(4);

        // R4 R5 R7: single byte write
        write_burst(8'h12, 8'h34, 1, 8'h5C, "R7 byte write");
        // R4 R6: high bits of the high byte dropped, page wrap 0x7E..0x40
        write_burst(8'hFF, 8'h7E, 3, 8'hA1, "R6 page wrap");
        // R7: stop after address only loads pointer, no commit
        write_burst(8'h03, 8'h99, 0, 8'h00, "R7 address only");

        // R2: wrong device code, later bytes ignored
        start_cond();
        send_byte(8'hBA, 1'b0, "R2 code mismatch");
        send_byte(8'h00, 1'b0, "R2 ignored byte");
        stop_cond();
        drained("R2 code mismatch");

        // R2: wrong select bits
        start_cond();
        send_byte(8'hA2, 1'b0, "R2 select mismatch");
        send_byte(8'h11, 1'b0, "R2 ignored after select");
        stop_cond();
        drained("R2 select mismatch");
        check(addr_ptr == model_ptr, "R2 pointer untouched", addr_ptr, model_ptr);

        // R3: read control byte
        exp_read++;
        start_cond();
        send_byte({4'b1010, STRAP, 1'b1}, 1'b1, "R3 read ack");
        stop_cond();
        drained("R3 read");

        // R8: busy before the control byte
        busy = 1'b1;
        start_cond();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b0, "R8 busy control");
        send_byte(8'h01, 1'b0, "R8 busy follow");
        stop_cond();
        busy = 1'b0;
        drained("R8 busy control");

        // R8: busy raised during the data phase
        start_cond();
        send_byte({4'b1010, STRAP, 1'b0}, 1'b1, "R8 control ack");
        send_byte(8'h04, 1'b1, "R8 high ack");
        send_byte(8'h20, 1'b1, "R8 low ack");
        busy = 1'b1;
        send_byte(8'h77, 1'b0, "R8 busy data");
        busy = 1'b0;
        send_byte(8'h78, 1'b0, "R8 idle data");
        stop_cond();
        drained("R8 busy data");
        model_ptr = {STRAP, 5'h04, 8'h20};
        check(addr_ptr == model_ptr, "R8 pointer not stepped", addr_ptr, model_ptr);

        // R9: start inside a byte restarts framing
        start_cond();
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        write_burst(8'h0A, 8'h3F, 2, 8'h42, "R9 restart");

        running = 1'b0;
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule